// File: doc/BRIEF.md
# Boot mode and address controller

This block decides where the processor begins fetching after a reset. Two strap pins select one of three start-up modes. In debug-attach mode the block waits while an external agent fills memory. In direct-flash mode the processor runs straight out of a memory-mapped flash window. In flash-load mode a loader first copies an image into RAM. On the first clock after reset is released, the block captures the straps and keeps them for the rest of the session. From then on it presents a decoded mode.

A small register port holds two values. One is a programmable boot address. The other is a preload-complete flag, which a simulation bench or a debugger can set once memory has been filled. A sequencer uses the decoded mode to pick the start address. In flash-load mode it first sends a one-cycle start request to the loader and then waits for the loader to finish. In debug-attach mode it waits without limit for either the preload flag or a debug-release pulse. It then hands the chosen address to the core with a one-cycle valid strobe, exactly once per reset.

Top module: `boot_ctl`

## Requirements
- R1: With `boot_sel_i` = 0 at the sampling edge, `mode_o` reads 2'b00 (debug-attach) whatever `exec_flash_i` is. `mode_valid_o` is 0 during reset and goes to 1 after the first rising clock edge following reset release.
- R2: With `boot_sel_i` = 1 and `exec_flash_i` = 1 at the sampling edge, `mode_o` reads 2'b01 (direct flash execution).
- R3: With `boot_sel_i` = 1 and `exec_flash_i` = 0 at the sampling edge, `mode_o` reads 2'b10 (flash-to-RAM load).
- R4: The straps are sampled only on the first rising edge after reset release. Any later change on them leaves `mode_o` and the boot sequence unchanged until the next reset.
- R5: The boot-address register sits at register offset 0 and resets to 0x180. A write stores `reg_wdata_i`. A read request returns the value on `reg_rdata_o` one cycle after the request edge.
- R6: In debug-attach mode no boot strobe occurs until bit 0 of register offset 1 (the preload flag) is written to 1. The strobe then appears two edges after the write edge and carries the boot-address register value.
- R7: In debug-attach mode, a `dbg_release_i` pulse sampled at an edge ends the wait. The boot strobe appears right after that edge and carries the boot-address register value.
- R8: In direct-flash mode the boot strobe appears after the second edge following reset release, with address flash base plus 0x180 (0x4_0000_0180 by default).
- R9: In flash-load mode `load_start_o` is high for exactly one cycle, after the second edge following reset release. `load_done_i` is ignored while `load_start_o` is high. A `load_done_i` sampled afterwards brings the boot strobe right after that edge, with address 0x180.
- R10: `boot_valid_o` is high for exactly one cycle per reset, and `boot_addr_o` is 0 whenever `boot_valid_o` is low. The preload flag and `dbg_release_i` have no effect outside debug-attach mode, and no effect once the strobe has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boot_sel_i | input | 1 | Strap: 0 selects debug-attach, 1 selects a flash mode |
| exec_flash_i | input | 1 | Strap: in flash modes, 1 executes in place and 0 loads to RAM |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | Register write enable (0 is a read) |
| reg_addr_i | input | REG_AW (2) | Register word offset: 0 boot address, 1 preload flag |
| reg_wdata_i | input | DW (32) | Register write data |
| reg_rdata_o | output | DW (32) | Register read data, one cycle after the request |
| dbg_release_i | input | 1 | Debug release pulse, used in debug-attach mode |
| load_done_i | input | 1 | Flash loader reports that the copy is finished |
| load_start_o | output | 1 | One-cycle request to start the flash loader |
| mode_o | output | 2 | Decoded boot mode |
| mode_valid_o | output | 1 | Mode has been sampled |
| boot_addr_o | output | ADDR_W (36) | Start address, non-zero only with the strobe |
| boot_valid_o | output | 1 | One-cycle boot address strobe |

## Verification
The mode is due one edge after reset release. A direct-flash strobe or a load start request is due one edge later. A strobe that follows a debug release or a loader completion is due one edge after that input is sampled. A strobe that follows a preload-flag write is due two edges after the write edge, because the flag register sits in between. The bench drives every input and samples every output on the falling clock edge. It counts edges from each stimulus and checks both the cycle before a strobe is due, which must be quiet, and the cycle it is due. A posedge monitor counts strobes across each whole session. The sweep covers all four strap combinations, each paired with a flag write and with a debug pulse.

// File: rtl/boot_ctl_pkg.sv
package boot_ctl_pkg;

   typedef enum logic [1:0] {
      BOOT_JTAG       = 2'd0,
      BOOT_FLASH_EXEC = 2'd1,
      BOOT_FLASH_LOAD = 2'd2
   } boot_mode_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_START,
      SQ_LOAD,
      SQ_WAIT,
      SQ_ISSUE,
      SQ_DONE
   } seq_state_e;

   function automatic boot_mode_e pick_mode(input logic sel, input logic exec);
      if (!sel)      return BOOT_JTAG;
      else if (exec) return BOOT_FLASH_EXEC;
      else           return BOOT_FLASH_LOAD;
   endfunction

endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
   import boot_ctl_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       boot_sel_i,
   input  logic       exec_flash_i,
   output boot_mode_e mode_o,
   output logic       valid_o
);

   boot_mode_e mode_q;
   logic       taken_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q  <= BOOT_JTAG;
         taken_q <= 1'b0;
      end else if (!taken_q) begin
         mode_q  <= pick_mode(boot_sel_i, exec_flash_i);
         taken_q <= 1'b1;
      end
   end

   assign mode_o  = mode_q;
   assign valid_o = taken_q;

   // R4: once captured, the mode never moves
   p_strap_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && $past(valid_o)) |-> $stable(mode_o));

   // R1: boot_sel low at the capture edge gives debug-attach
   p_mode_jtag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !$past(valid_o) && !$past(boot_sel_i)) |-> (mode_o == BOOT_JTAG));

   // R2: both straps high give direct execution
   p_mode_exec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !$past(valid_o) && $past(boot_sel_i) && $past(exec_flash_i))
      |-> (mode_o == BOOT_FLASH_EXEC));

   // R3: select high, execute low gives load
   p_mode_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !$past(valid_o) && $past(boot_sel_i) && !$past(exec_flash_i))
      |-> (mode_o == BOOT_FLASH_LOAD));

endmodule

// File: rtl/boot_regs.sv
module boot_regs #(
   parameter int unsigned     DW         = 32,
   parameter int unsigned     REG_AW     = 2,
   parameter logic [DW-1:0]   RESET_ADDR = 32'h180,
   parameter bit              READ_REG   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              reg_req_i,
   input  logic              reg_we_i,
   input  logic [REG_AW-1:0] reg_addr_i,
   input  logic [DW-1:0]     reg_wdata_i,
   output logic [DW-1:0]     reg_rdata_o,
   output logic [DW-1:0]     boot_reg_o,
   output logic              preload_o
);

   localparam logic [REG_AW-1:0] OFS_ADDR = REG_AW'(0);
   localparam logic [REG_AW-1:0] OFS_FLAG = REG_AW'(1);

   if (DW < 8 || DW > 64) begin : g_bad_dw
      $error("boot_regs: DW must lie in 8..64");
   end
   if (REG_AW < 1) begin : g_bad_aw
      $error("boot_regs: REG_AW must be at least 1");
   end

   logic [DW-1:0] addr_q;
   logic          flag_q;
   logic [DW-1:0] rd_mux;
   logic          wr_addr, wr_flag, rd_req;

   assign wr_addr = reg_req_i && reg_we_i && (reg_addr_i == OFS_ADDR);
   assign wr_flag = reg_req_i && reg_we_i && (reg_addr_i == OFS_FLAG);
   assign rd_req  = reg_req_i && !reg_we_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         addr_q <= RESET_ADDR;
         flag_q <= 1'b0;
      end else begin
         if (wr_addr) addr_q <= reg_wdata_i;
         if (wr_flag) flag_q <= reg_wdata_i[0];
      end
   end

   always_comb begin
      rd_mux = '0;
      if (reg_addr_i == OFS_ADDR)      rd_mux = addr_q;
      else if (reg_addr_i == OFS_FLAG) rd_mux = {{(DW-1){1'b0}}, flag_q};
   end

   if (READ_REG) begin : g_rd_reg
      logic [DW-1:0] rdata_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     rdata_q <= '0;
         else if (rd_req) rdata_q <= rd_mux;
      end
      assign reg_rdata_o = rdata_q;
   end else begin : g_rd_comb
      assign reg_rdata_o = rd_req ? rd_mux : '0;
   end

   assign boot_reg_o = addr_q;
   assign preload_o  = flag_q;

   // R5: a write to offset 0 lands in the boot-address register
   p_addr_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_req_i && reg_we_i && reg_addr_i == OFS_ADDR) |=> (boot_reg_o == $past(reg_wdata_i)));

   // R6: the flag tracks bit 0 of a write to offset 1
   p_flag_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_req_i && reg_we_i && reg_addr_i == OFS_FLAG) |=> (preload_o == $past(reg_wdata_i[0])));

endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
   import boot_ctl_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 36,
   parameter int unsigned       DW         = 32,
   parameter logic [ADDR_W-1:0] FLASH_BASE = 36'h4_0000_0000,
   parameter logic [ADDR_W-1:0] RAM_BASE   = '0,
   parameter logic [ADDR_W-1:0] ENTRY_OFS  = 36'h180
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  boot_mode_e        mode_i,
   input  logic              mode_valid_i,
   input  logic              preload_i,
   input  logic              dbg_release_i,
   input  logic              load_done_i,
   input  logic [DW-1:0]     boot_reg_i,
   output logic              load_start_o,
   output logic [ADDR_W-1:0] boot_addr_o,
   output logic              boot_valid_o
);

   localparam logic [ADDR_W-1:0] EXEC_ADDR = FLASH_BASE + ENTRY_OFS;
   localparam logic [ADDR_W-1:0] LOAD_ADDR = RAM_BASE + ENTRY_OFS;

   seq_state_e        state_q, state_d;
   logic [ADDR_W-1:0] addr_q, sel_addr, reg_ext;

   if (DW >= ADDR_W) begin : g_reg_trunc
      assign reg_ext = boot_reg_i[ADDR_W-1:0];
   end else begin : g_reg_zext
      assign reg_ext = {{(ADDR_W-DW){1'b0}}, boot_reg_i};
   end

   always_comb begin
      case (mode_i)
         BOOT_FLASH_EXEC: sel_addr = EXEC_ADDR;
         BOOT_FLASH_LOAD: sel_addr = LOAD_ADDR;
         default:         sel_addr = reg_ext;
      endcase
   end

   always_comb begin
      state_d = state_q;
      case (state_q)
         SQ_IDLE: begin
            if (mode_valid_i) begin
               case (mode_i)
                  BOOT_FLASH_EXEC: state_d = SQ_ISSUE;
                  BOOT_FLASH_LOAD: state_d = SQ_START;
                  default:         state_d = SQ_WAIT;
               endcase
            end
         end
         SQ_START: state_d = SQ_LOAD;
         SQ_LOAD:  if (load_done_i) state_d = SQ_ISSUE;
         SQ_WAIT:  if (preload_i || dbg_release_i) state_d = SQ_ISSUE;
         SQ_ISSUE: state_d = SQ_DONE;
         default:  state_d = SQ_DONE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= SQ_IDLE;
         addr_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_d == SQ_ISSUE && state_q != SQ_ISSUE) addr_q <= sel_addr;
      end
   end

   assign load_start_o = (state_q == SQ_START);
   assign boot_valid_o = (state_q == SQ_ISSUE);
   assign boot_addr_o  = boot_valid_o ? addr_q : '0;

   // R10: the strobe lasts a single cycle
   p_one_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      boot_valid_o |=> !boot_valid_o);

   // R10: after issue the sequencer never leaves its final state
   p_done_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == SQ_DONE) |=> (state_q == SQ_DONE));

   // R9: start request is a single cycle and only in load mode
   p_start_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_start_o |=> !load_start_o);
   p_start_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_start_o |-> (mode_i == BOOT_FLASH_LOAD));

   // R9: a load-mode strobe always follows a sampled completion
   p_load_after_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (boot_valid_o && mode_i == BOOT_FLASH_LOAD) |-> $past(load_done_i));

   // R8: direct execution starts at the flash entry
   p_exec_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (boot_valid_o && mode_i == BOOT_FLASH_EXEC) |-> (boot_addr_o == EXEC_ADDR));

   // R6, R7: a debug-attach strobe needs a flag or a release one edge earlier
   p_jtag_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (boot_valid_o && mode_i == BOOT_JTAG) |-> $past(preload_i || dbg_release_i));

   // R6: the wait holds while neither release source is present
   p_wait_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == SQ_WAIT && !preload_i && !dbg_release_i) |=> !boot_valid_o);

endmodule

// File: rtl/boot_ctl.sv
module boot_ctl
   import boot_ctl_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 36,
   parameter int unsigned       DW         = 32,
   parameter int unsigned       REG_AW     = 2,
   parameter logic [ADDR_W-1:0] FLASH_BASE = 36'h4_0000_0000,
   parameter logic [ADDR_W-1:0] RAM_BASE   = '0,
   parameter logic [ADDR_W-1:0] ENTRY_OFS  = 36'h180,
   parameter bit                READ_REG   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              boot_sel_i,
   input  logic              exec_flash_i,
   input  logic              reg_req_i,
   input  logic              reg_we_i,
   input  logic [REG_AW-1:0] reg_addr_i,
   input  logic [DW-1:0]     reg_wdata_i,
   output logic [DW-1:0]     reg_rdata_o,
   input  logic              dbg_release_i,
   input  logic              load_done_i,
   output logic              load_start_o,
   output logic [1:0]        mode_o,
   output logic              mode_valid_o,
   output logic [ADDR_W-1:0] boot_addr_o,
   output logic              boot_valid_o
);

   localparam logic [DW-1:0] REG_RESET = DW'(ENTRY_OFS);

   if (ADDR_W < 16 || ADDR_W > 64) begin : g_bad_addr_w
      $error("boot_ctl: ADDR_W must lie in 16..64");
   end
   if (ENTRY_OFS[1:0] != 2'b00) begin : g_bad_entry
      $error("boot_ctl: ENTRY_OFS must be word aligned");
   end
   if (FLASH_BASE == RAM_BASE) begin : g_bad_bases
      $error("boot_ctl: flash and RAM bases must differ");
   end

   boot_mode_e    mode;
   logic          mode_valid;
   logic [DW-1:0] boot_reg;
   logic          preload;

   boot_strap_latch u_strap (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .boot_sel_i   (boot_sel_i),
      .exec_flash_i (exec_flash_i),
      .mode_o       (mode),
      .valid_o      (mode_valid)
   );

   boot_regs #(
      .DW         (DW),
      .REG_AW     (REG_AW),
      .RESET_ADDR (REG_RESET),
      .READ_REG   (READ_REG)
   ) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .reg_req_i   (reg_req_i),
      .reg_we_i    (reg_we_i),
      .reg_addr_i  (reg_addr_i),
      .reg_wdata_i (reg_wdata_i),
      .reg_rdata_o (reg_rdata_o),
      .boot_reg_o  (boot_reg),
      .preload_o   (preload)
   );

   boot_seq_fsm #(
      .ADDR_W     (ADDR_W),
      .DW         (DW),
      .FLASH_BASE (FLASH_BASE),
      .RAM_BASE   (RAM_BASE),
      .ENTRY_OFS  (ENTRY_OFS)
   ) u_seq (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .mode_i        (mode),
      .mode_valid_i  (mode_valid),
      .preload_i     (preload),
      .dbg_release_i (dbg_release_i),
      .load_done_i   (load_done_i),
      .boot_reg_i    (boot_reg),
      .load_start_o  (load_start_o),
      .boot_addr_o   (boot_addr_o),
      .boot_valid_o  (boot_valid_o)
   );

   assign mode_o       = mode;
   assign mode_valid_o = mode_valid;

   // R10: nothing is issued before the mode is known
   p_no_early_issue_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      boot_valid_o |-> mode_valid_o);

   // R1: the start request never appears in debug-attach mode
   p_no_start_jtag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b00) |-> !load_start_o);

endmodule

// File: tb/boot_ctl_test.sv
module boot_ctl_test;

   localparam int ADDR_W = 36;
   localparam int DW     = 32;
   localparam int REG_AW = 2;
   localparam logic [ADDR_W-1:0] EXP_EXEC = 36'h4_0000_0000 + 36'h180;
   localparam logic [ADDR_W-1:0] EXP_LOAD = 36'h180;

   logic              clk_i = 1'b0;
   logic              rst_ni = 1'b0;
   logic              boot_sel_i = 1'b0;
   logic              exec_flash_i = 1'b0;
   logic              reg_req_i = 1'b0;
   logic              reg_we_i = 1'b0;
   logic [REG_AW-1:0] reg_addr_i = '0;
   logic [DW-1:0]     reg_wdata_i = '0;
   logic [DW-1:0]     reg_rdata_o;
   logic              dbg_release_i = 1'b0;
   logic              load_done_i = 1'b0;
   logic              load_start_o;
   logic [1:0]        mode_o;
   logic              mode_valid_o;
   logic [ADDR_W-1:0] boot_addr_o;
   logic              boot_valid_o;

   boot_ctl uut (
      .clk_i, .rst_ni, .boot_sel_i, .exec_flash_i,
      .reg_req_i, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
      .dbg_release_i, .load_done_i, .load_start_o,
      .mode_o, .mode_valid_o, .boot_addr_o, .boot_valid_o
   );

   always #5 clk_i = ~clk_i;

   int checks = 0;
   int errors = 0;
   int vcount = 0;
   bit finished = 1'b0;

   always @(posedge clk_i) if (rst_ni && boot_valid_o) vcount <= vcount + 1;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk_i);
   endtask

   task automatic reg_write(input logic [REG_AW-1:0] a, input logic [DW-1:0] d);
      reg_req_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
      tick();
      reg_req_i = 1'b0; reg_we_i = 1'b0;
   endtask

   task automatic reg_read(input logic [REG_AW-1:0] a, output logic [DW-1:0] d);
      reg_req_i = 1'b1; reg_we_i = 1'b0; reg_addr_i = a;
      tick();
      d = reg_rdata_o;
      reg_req_i = 1'b0;
   endtask

   task automatic dbg_pulse();
      dbg_release_i = 1'b1;
      tick();
      dbg_release_i = 1'b0;
   endtask

   initial begin
      logic [DW-1:0] rd;
      logic [DW-1:0] val;
      logic [1:0]    exp_mode;
      for (int combo = 0; combo < 4; combo++) begin
         for (int m = 0; m < 2; m++) begin
            tick();
            rst_ni = 1'b0;
            boot_sel_i = combo[1]; exec_flash_i = combo[0];
            load_done_i = 1'b0; dbg_release_i = 1'b0; reg_req_i = 1'b0;
            exp_mode = !combo[1] ? 2'b00 : (combo[0] ? 2'b01 : 2'b10);
            tick(); tick();
            chk(!mode_valid_o, "R1 mode_valid in reset", 64'(mode_valid_o), 0);
            chk(!boot_valid_o && !load_start_o, "R10 outputs quiet in reset",
                64'({boot_valid_o, load_start_o}), 0);
            vcount = 0;
            rst_ni = 1'b1;
            tick();
            chk(mode_valid_o, "R1 mode_valid after first edge", 64'(mode_valid_o), 1);
            chk(mode_o == exp_mode, exp_mode == 0 ? "R1 mode" : (exp_mode == 1 ? "R2 mode" : "R3 mode"),
                64'(mode_o), 64'(exp_mode));
            boot_sel_i = ~boot_sel_i; exec_flash_i = ~exec_flash_i;
            tick();
            case (exp_mode)
               2'b00: begin
                  chk(!boot_valid_o, "R6 wait holds", 64'(boot_valid_o), 0);
                  reg_read(0, rd);
                  chk(rd == 32'h180, "R5 reset value", 64'(rd), 64'h180);
                  val = 32'h1000 + 32'(combo * 64) + 32'(m * 4);
                  reg_write(0, val);
                  reg_read(0, rd);
                  chk(rd == val, "R5 readback", 64'(rd), 64'(val));
                  for (int i = 0; i < 4; i++) begin
                     tick();
                     chk(!boot_valid_o, "R6 wait holds", 64'(boot_valid_o), 0);
                  end
                  if (m == 0) begin
                     reg_write(1, 32'h1);
                     chk(!boot_valid_o, "R6 not yet", 64'(boot_valid_o), 0);
                     tick();
                     chk(boot_valid_o, "R6 strobe after flag", 64'(boot_valid_o), 1);
                     chk(boot_addr_o == 36'(val), "R6 address", 64'(boot_addr_o), 64'(val));
                  end else begin
                     dbg_pulse();
                     chk(boot_valid_o, "R7 strobe after release", 64'(boot_valid_o), 1);
                     chk(boot_addr_o == 36'(val), "R7 address", 64'(boot_addr_o), 64'(val));
                  end
               end
               2'b01: begin
                  chk(boot_valid_o, "R8 strobe", 64'(boot_valid_o), 1);
                  chk(boot_addr_o == EXP_EXEC, "R8 address", 64'(boot_addr_o), 64'(EXP_EXEC));
                  chk(!load_start_o, "R9 no start in exec", 64'(load_start_o), 0);
                  if (m == 0) reg_write(1, 32'h1);
                  else dbg_pulse();
               end
               default: begin
                  chk(load_start_o, "R9 start pulse", 64'(load_start_o), 1);
                  chk(!boot_valid_o, "R9 no strobe yet", 64'(boot_valid_o), 0);
                  load_done_i = 1'b1;
                  tick();
                  load_done_i = 1'b0;
                  chk(!load_start_o, "R9 start one cycle", 64'(load_start_o), 0);
                  chk(!boot_valid_o, "R9 early done ignored", 64'(boot_valid_o), 0);
                  if (m == 0) reg_write(1, 32'h1);
                  else dbg_pulse();
                  for (int i = 0; i < 3; i++) begin
                     tick();
                     chk(!boot_valid_o, "R10 release ignored in load", 64'(boot_valid_o), 0);
                  end
                  load_done_i = 1'b1;
                  tick();
                  load_done_i = 1'b0;
                  chk(boot_valid_o, "R9 strobe after done", 64'(boot_valid_o), 1);
                  chk(boot_addr_o == EXP_LOAD, "R9 address", 64'(boot_addr_o), 64'(EXP_LOAD));
               end
            endcase
            tick();
            chk(!boot_valid_o && boot_addr_o == '0, "R10 strobe single cycle",
                64'(boot_addr_o), 0);
            dbg_pulse();
            reg_write(1, 32'h1);
            for (int i = 0; i < 6; i++) tick();
            chk(vcount == 1, "R10 one strobe per reset", 64'(vcount), 1);
            chk(mode_o == exp_mode, "R4 mode held", 64'(mode_o), 64'(exp_mode));
         end
      end
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk_i);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule